// File: doc/BRIEF.md
# CAN Controller Command and Interrupt Unit

This block is the host-facing control core of a CAN controller. A byte-wide register bus reaches five registers: a mode register, a write-only command register, a status register, an interrupt flag register and an interrupt enable register. The unit turns command writes into one-cycle actions and never stores the command bits. It keeps the status and interrupt bits in step with transmit and receive events. It drives a level interrupt line that is high while any enabled flag is set.

Transmission is a valid/ready handshake toward an external frame engine. Receive activity comes from a neighbouring receive buffer as one-cycle strobes: reception started, frame dropped, frame stored and overrun. The unit counts the buffered messages and sends a release strobe back to the receive buffer when the host frees a message. It sends a software-reset strobe so the receive buffer can rewind its read pointer. It sends an operating-mode entry strobe so the filters can be reloaded.

The register map is: 0 mode, 1 command, 2 status, 3 interrupt flags, 4 interrupt enable, and 16 to 28 the transmit buffer window. The bytes written to that window are held outside this unit.

Top module: `can_cmd_irq_unit`

## Requirements
- R1: A synchronous reset gives mode 0x01 (reset mode), status 0x3C, interrupt flags 0x00, enable 0x00, tx_valid low and irq low.
- R2: A mode write keeps only wdata[4:0]. A mode read returns those bits with bits 7:5 zero. reset_mode follows mode bit 0 and single_filter follows mode bit 3. Reads of the command register and of unmapped addresses return 0x00.
- R3: When a mode write takes bit 0 from 1 to 0, op_enter pulses for one cycle. When a mode write takes bit 0 from 0 to 1, a software reset runs: status bits 1 and 0 become 0, status bits 2, 4 and 5 become 1, bit 3 is kept, the message count becomes zero and sw_rst pulses for one cycle.
- R4: Command bit 0, written in operating mode while no frame is pending, clears status bits 2 and 3 and raises tx_valid on the next cycle. tx_valid then stays high until tx_ready is seen. The same request is ignored in reset mode or while a frame is pending.
- R5: A cycle with tx_valid and tx_ready both high completes the transfer. tx_valid drops, status bits 2 and 3 are set, status bit 5 is cleared and interrupt flag bit 1 (transmit) is set.
- R6: Any write to addresses 16 to 28 sets status bit 5.
- R7: In operating mode, rx_store increments the message count, sets interrupt flag bit 0 and clears status bit 4. rx_begin sets status bit 4 and rx_drop clears it. Status bit 0 reads 1 while the count is non-zero. In reset mode all four receive strobes have no effect.
- R8: Command bit 2 with a non-zero count decrements the count and pulses rx_release on the next cycle. When the count reaches zero, status bit 0 and flag bit 0 clear. With a zero count the command has no effect.
- R9: rx_overrun, in operating mode, sets status bit 1 and flag bit 3 and clears status bit 4. Command bit 3 clears status bit 1 and flag bit 3.
- R10: A read of the flag register returns the flags and clears them. Flag bit 0 is set again at once if the message count is non-zero.
- R11: irq is high exactly when the enable register and the flag register share a set bit, one cycle after either register changes.
- R12: Read data appears on rdata one cycle after rd_en and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| tx_valid | output | 1 | Frame ready for the transmit engine |
| tx_ready | input | 1 | Transmit engine accepts the frame |
| rx_begin | input | 1 | Reception has started |
| rx_drop | input | 1 | Received frame discarded |
| rx_store | input | 1 | Received frame stored in the buffer |
| rx_overrun | input | 1 | Received frame lost for lack of space |
| rx_release | output | 1 | One-cycle pulse: free the oldest message |
| sw_rst | output | 1 | One-cycle pulse: software reset taken |
| op_enter | output | 1 | One-cycle pulse: operating mode entered |
| reset_mode | output | 1 | Mode bit 0 |
| single_filter | output | 1 | Mode bit 3 |
| irq | output | 1 | Level interrupt |

## Verification
The assertions take for granted that the host never raises wr_en and rd_en in the same cycle. They also assume that the receive buffer sends at most one receive strobe per cycle and never stores more messages than the count can hold. The bench keeps to these rules: it drives one bus operation or one receive strobe per cycle, and it stops issuing rx_store once its own model holds thirty messages. tx_ready may rise at any time, so the handshake is exercised both with a waiting engine and with an engine that is already ready.

// File: rtl/can_cmd_irq_unit.sv
module can_cmd_irq_unit #(
  parameter int ADDR_W    = 5,
  parameter int CNT_W     = 6,
  parameter int TXB_FIRST = 16,
  parameter int TXB_LAST  = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic              rx_begin,
  input  logic              rx_drop,
  input  logic              rx_store,
  input  logic              rx_overrun,
  output logic              rx_release,
  output logic              sw_rst,
  output logic              op_enter,
  output logic              reset_mode,
  output logic              single_filter,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_TXLO = ADDR_W'(TXB_FIRST);
  localparam logic [ADDR_W-1:0] A_TXHI = ADDR_W'(TXB_LAST);
  localparam logic [CNT_W-1:0]  CNT_MAX = '1;

  logic [4:0]       mode_q, mode_n;
  logic [5:1]       st_q, st_n;
  logic [3:0]       flag_q, fl_n;
  logic [7:0]       ien_q, ien_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             txv_q, txv_n;
  logic [7:0]       rd_n;
  logic             rel_n, swr_n, ope_n;

  wire has_msg   = (cnt_q != '0);
  wire [7:0] stat_byte = {2'b00, st_q, has_msg};
  wire wr_cmd    = wr_en && (addr == A_CMD);
  wire wr_mode   = wr_en && (addr == A_MODE);
  wire wr_txbuf  = wr_en && (addr >= A_TXLO) && (addr <= A_TXHI);
  wire rx_live   = !mode_q[0];

  always_comb begin
    mode_n = mode_q;
    st_n   = st_q;
    fl_n   = flag_q;
    ien_n  = ien_q;
    cnt_n  = cnt_q;
    txv_n  = txv_q;
    rd_n   = rdata;
    rel_n  = 1'b0;
    swr_n  = 1'b0;
    ope_n  = 1'b0;

    if (rd_en) begin
      case (addr)
        A_MODE:  rd_n = {3'b000, mode_q};
        A_STAT:  rd_n = stat_byte;
        A_FLAG:  rd_n = {4'b0000, flag_q};
        A_IEN:   rd_n = ien_q;
        default: rd_n = 8'h00;
      endcase
      if (addr == A_FLAG) fl_n = {3'b000, has_msg};
    end

    if (wr_en && addr == A_IEN) ien_n = wdata;

    if (wr_cmd) begin
      if (wdata[0] && rx_live && !txv_q) begin
        txv_n   = 1'b1;
        st_n[2] = 1'b0;
        st_n[3] = 1'b0;
      end
      if (wdata[2] && has_msg) begin
        cnt_n = cnt_q - 1'b1;
        rel_n = 1'b1;
        if (cnt_n == '0) fl_n[0] = 1'b0;
      end
      if (wdata[3]) begin
        st_n[1] = 1'b0;
        fl_n[3] = 1'b0;
      end
    end

    if (txv_q && tx_ready) begin
      txv_n   = 1'b0;
      st_n[2] = 1'b1;
      st_n[3] = 1'b1;
      st_n[5] = 1'b0;
      fl_n[1] = 1'b1;
    end

    if (wr_txbuf) st_n[5] = 1'b1;

    if (rx_live) begin
      if (rx_begin) st_n[4] = 1'b1;
      if (rx_drop)  st_n[4] = 1'b0;
      if (rx_overrun) begin
        st_n[1] = 1'b1;
        fl_n[3] = 1'b1;
        st_n[4] = 1'b0;
      end
      if (rx_store) begin
        if (cnt_n != CNT_MAX) cnt_n = cnt_n + 1'b1;
        fl_n[0] = 1'b1;
        st_n[4] = 1'b0;
      end
    end

    if (wr_mode) begin
      mode_n = wdata[4:0];
      if (mode_q[0] && !wdata[0]) ope_n = 1'b1;
      if (!mode_q[0] && wdata[0]) begin
        swr_n   = 1'b1;
        st_n[1] = 1'b0;
        st_n[2] = 1'b1;
        st_n[4] = 1'b1;
        st_n[5] = 1'b1;
        cnt_n   = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= 5'h01;
      st_q       <= 5'b11110;
      flag_q     <= '0;
      ien_q      <= '0;
      cnt_q      <= '0;
      txv_q      <= 1'b0;
      rdata      <= '0;
      rx_release <= 1'b0;
      sw_rst     <= 1'b0;
      op_enter   <= 1'b0;
    end else begin
      mode_q     <= mode_n;
      st_q       <= st_n;
      flag_q     <= fl_n;
      ien_q      <= ien_n;
      cnt_q      <= cnt_n;
      txv_q      <= txv_n;
      rdata      <= rd_n;
      rx_release <= rel_n;
      sw_rst     <= swr_n;
      op_enter   <= ope_n;
    end
  end

  assign tx_valid      = txv_q;
  assign reset_mode    = mode_q[0];
  assign single_filter = mode_q[3];
  assign irq           = |(ien_q & {4'b0000, flag_q});
endmodule

// File: rtl/can_cmd_irq_chk.sv
module can_cmd_irq_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             rx_store,
  input logic             rx_release,
  input logic             sw_rst,
  input logic             irq,
  input logic [4:0]       mode_q,
  input logic [5:1]       st_q,
  input logic [3:0]       flag_q,
  input logic [7:0]       ien_q,
  input logic [CNT_W-1:0] cnt_q
);
  // R5
  tx_done_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> (!tx_valid && st_q[2] && st_q[3] && flag_q[1]));

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> tx_valid);

  // R4
  tx_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> (!st_q[2] && !st_q[3]));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (rst)
    rx_release |-> ($past(cnt_q) != '0));

  // R3
  soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
    sw_rst |-> (st_q[5] && st_q[4] && st_q[2] && !st_q[1] && cnt_q == '0 && mode_q[0]));

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (ien_q == 8'h00) |-> !irq);

  // R7
  rx_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q[0] && rx_store) |=> (cnt_q <= $past(cnt_q)));
endmodule

bind can_cmd_irq_unit can_cmd_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_store(rx_store), .rx_release(rx_release), .sw_rst(sw_rst), .irq(irq),
  .mode_q(mode_q), .st_q(st_q), .flag_q(flag_q), .ien_q(ien_q), .cnt_q(cnt_q)
);

// File: tb/tb_can_cmd_irq_unit.sv
`timescale 1ns/1ps
module tb_can_cmd_irq_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, rd_en = 0, tx_ready = 0;
  logic rx_begin = 0, rx_drop = 0, rx_store = 0, rx_overrun = 0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic tx_valid, rx_release, sw_rst, op_enter, reset_mode, single_filter, irq;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  can_cmd_irq_unit dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_begin(rx_begin),
    .rx_drop(rx_drop), .rx_store(rx_store), .rx_overrun(rx_overrun),
    .rx_release(rx_release), .sw_rst(sw_rst), .op_enter(op_enter),
    .reset_mode(reset_mode), .single_filter(single_filter), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference
  int m_cnt, oc;
  bit [7:0] m_st, m_fl, m_ien, m_rd;
  bit [4:0] m_mode, om;
  bit m_txv, m_rel, m_swr, m_ope, otx;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 5'h01; m_st = 8'h3C; m_fl = 0; m_ien = 0; m_cnt = 0;
      m_txv = 0; m_rd = 0; m_rel = 0; m_swr = 0; m_ope = 0;
    end else begin
      om = m_mode; oc = m_cnt; otx = m_txv;
      m_rel = 0; m_swr = 0; m_ope = 0;
      if (rd_en) begin
        if (addr == 0) m_rd = {3'b000, om};
        else if (addr == 2) m_rd = m_st | ((oc != 0) ? 8'h01 : 8'h00);
        else if (addr == 3) m_rd = m_fl;
        else if (addr == 4) m_rd = m_ien;
        else m_rd = 8'h00;
        if (addr == 3) m_fl = (oc != 0) ? 8'h01 : 8'h00;
      end
      if (wr_en && addr == 4) m_ien = wdata;
      if (wr_en && addr == 1) begin
        if (wdata[0] && !om[0] && !otx) begin m_txv = 1; m_st[3] = 0; m_st[2] = 0; end
        if (wdata[2] && oc > 0) begin
          m_cnt = oc - 1; m_rel = 1;
          if (m_cnt == 0) m_fl[0] = 0;
        end
        if (wdata[3]) begin m_st[1] = 0; m_fl[3] = 0; end
      end
      if (otx && tx_ready) begin
        m_txv = 0; m_st[3] = 1; m_st[2] = 1; m_st[5] = 0; m_fl[1] = 1;
      end
      if (wr_en && addr >= 16 && addr <= 28) m_st[5] = 1;
      if (!om[0]) begin
        if (rx_begin) m_st[4] = 1;
        if (rx_drop) m_st[4] = 0;
        if (rx_overrun) begin m_st[1] = 1; m_fl[3] = 1; m_st[4] = 0; end
        if (rx_store) begin
          if (m_cnt < 63) m_cnt++;
          m_fl[0] = 1; m_st[4] = 0;
        end
      end
      if (wr_en && addr == 0) begin
        m_mode = wdata[4:0];
        if (om[0] && !wdata[0]) m_ope = 1;
        if (!om[0] && wdata[0]) begin
          m_swr = 1; m_st[1] = 0; m_st[2] = 1; m_st[4] = 1; m_st[5] = 1; m_cnt = 0;
        end
      end
    end
  end

  always begin
    @(posedge clk); #5;
    check("R11 irq", {7'b0, irq}, {7'b0, |(m_ien & m_fl)});
    check("R4 tx_valid", {7'b0, tx_valid}, {7'b0, m_txv});
    check("R12 rdata", rdata, m_rd);
    check("R8 rx_release", {7'b0, rx_release}, {7'b0, m_rel});
    check("R3 sw_rst", {7'b0, sw_rst}, {7'b0, m_swr});
    check("R3 op_enter", {7'b0, op_enter}, {7'b0, m_ope});
    check("R2 mode pins", {6'b0, reset_mode, single_filter}, {6'b0, m_mode[0], m_mode[3]});
  end

  task automatic cyc(input logic w, input logic r, input logic [4:0] a,
                     input logic [7:0] d, input logic [3:0] rx);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    {rx_begin, rx_drop, rx_store, rx_overrun} = rx;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 8'h00, 4'b0000);
  endtask

  task automatic rd_check(input logic [4:0] a, input logic [7:0] exp, input string tag);
    cyc(0, 1, a, 8'h00, 4'b0000);
    idle();
    check(tag, rdata, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
    rd_check(0, 8'h01, "R1 mode");
    rd_check(2, 8'h3C, "R1 status");
    rd_check(3, 8'h00, "R1 flags");
    rd_check(4, 8'h00, "R1 enable");
    // R2 mode width and dead reads
    cyc(1, 0, 0, 8'hE8, 4'b0000);
    idle();
    check("R3 op_enter pulse", {7'b0, op_enter}, 8'h01);
    rd_check(0, 8'h08, "R2 mode low bits");
    check("R2 single_filter", {7'b0, single_filter}, 8'h01);
    rd_check(1, 8'h00, "R2 command read");
    rd_check(7, 8'h00, "R2 unmapped read");
    // R7 receive status and count
    cyc(1, 0, 4, 8'h0B, 4'b0000);
    cyc(0, 0, 0, 8'h00, 4'b0100);
    rd_check(2, 8'h2C, "R7 drop clears bit4");
    cyc(0, 0, 0, 8'h00, 4'b1000);
    rd_check(2, 8'h3C, "R7 begin sets bit4");
    cyc(0, 0, 0, 8'h00, 4'b0010);
    cyc(0, 0, 0, 8'h00, 4'b0010);
    rd_check(2, 8'h2D, "R7 stored status");
    check("R11 irq on receive", {7'b0, irq}, 8'h01);
    // R10 clear on read with refill
    rd_check(3, 8'h01, "R10 first flag read");
    rd_check(3, 8'h01, "R10 flag refilled");
    // R8 release
    cyc(1, 0, 1, 8'h04, 4'b0000);
    cyc(1, 0, 1, 8'h04, 4'b0000);
    idle();
    rd_check(2, 8'h2C, "R8 empty status");
    check("R8 irq drops", {7'b0, irq}, 8'h00);
    rd_check(3, 8'h00, "R8 flag cleared");
    cyc(1, 0, 1, 8'h04, 4'b0000);
    idle();
    check("R8 no release when empty", {7'b0, rx_release}, 8'h00);
    rd_check(2, 8'h2C, "R8 status unchanged");
    // R5 immediate completion
    tx_ready = 1;
    cyc(1, 0, 1, 8'h01, 4'b0000);
    idle(); idle();
    rd_check(2, 8'h0C, "R5 completion status");
    rd_check(3, 8'h02, "R5 transmit flag");
    // R6 buffer write
    tx_ready = 0;
    cyc(1, 0, 20, 8'h55, 4'b0000);
    idle();
    rd_check(2, 8'h2C, "R6 buffer write sets bit5");
    // R4 waiting engine
    cyc(1, 0, 1, 8'h01, 4'b0000);
    idle();
    rd_check(2, 8'h20, "R4 pending status");
    cyc(1, 0, 1, 8'h01, 4'b0000);
    idle(); idle(); idle();
    check("R4 valid held", {7'b0, tx_valid}, 8'h01);
    idle();
    tx_ready = 1;
    idle();
    tx_ready = 0;
    idle();
    check("R5 valid dropped", {7'b0, tx_valid}, 8'h00);
    rd_check(2, 8'h0C, "R5 second completion");
    // R9 overrun
    cyc(0, 0, 0, 8'h00, 4'b0001);
    idle();
    rd_check(2, 8'h0E, "R9 overrun status");
    rd_check(3, 8'h0A, "R9 overrun flag");
    cyc(0, 0, 0, 8'h00, 4'b0001);
    cyc(1, 0, 1, 8'h08, 4'b0000);
    idle();
    rd_check(2, 8'h0C, "R9 overrun cleared");
    rd_check(3, 8'h00, "R9 flag cleared");
    // R3 software reset, R7 and R4 in reset mode
    cyc(0, 0, 0, 8'h00, 4'b0010);
    idle();
    rd_check(2, 8'h0D, "R7 one stored");
    cyc(1, 0, 0, 8'h01, 4'b0000);
    idle();
    check("R3 sw_rst pulse", {7'b0, sw_rst}, 8'h01);
    rd_check(2, 8'h3C, "R3 status after soft reset");
    cyc(0, 0, 0, 8'h00, 4'b0010);
    cyc(0, 0, 0, 8'h00, 4'b0001);
    cyc(0, 0, 0, 8'h00, 4'b0100);
    rd_check(2, 8'h3C, "R7 strobes ignored in reset mode");
    cyc(1, 0, 1, 8'h01, 4'b0000);
    idle(); idle();
    check("R4 no request in reset mode", {7'b0, tx_valid}, 8'h00);
    // mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic [4:0] a;
      logic [7:0] d;
      sel = $urandom % 10;
      d = 8'($urandom);
      case ($urandom % 7)
        0: a = 5'd0;
        1: a = 5'd1;
        2: a = 5'd2;
        3: a = 5'd3;
        4: a = 5'd4;
        5: a = 5'(16 + $urandom % 13);
        default: a = 5'($urandom);
      endcase
      if (a == 0 && ($urandom % 4) != 0) d[0] = 1'b0;
      @(negedge clk);
      tx_ready = (($urandom % 3) == 0);
      wr_en = 0; rd_en = 0; addr = a; wdata = d;
      {rx_begin, rx_drop, rx_store, rx_overrun} = 4'b0000;
      if (sel < 2) wr_en = 1;
      else if (sel < 5) rd_en = 1;
      else if (sel == 5) rx_begin = 1;
      else if (sel == 6) rx_drop = 1;
      else if (sel == 7) rx_store = (m_cnt < 30);
      else if (sel == 8) rx_overrun = 1;
    end
    idle(); idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule